// File: doc/BRIEF.md
# Filtered Gate-Kill Output Stage

This block sits between a three-phase PWM generator and the gate-driver pins. It registers six phase gate signals and one power-factor-correction (PFC) gate signal, and applies a per-output active polarity. Two fault pins feed it. The main fault pin shuts off all six phase gates. The PFC fault pin shuts off only the PFC gate.

Each fault pin passes through a two-flop synchroniser and a polarity select. A consecutive-sample counter then acts as a glitch filter: a short pulse is ignored, and a sustained fault trips the channel. A tripped channel stays latched until it is cleared. A clear takes effect only once the synchronised pin has returned to its idle level. While a channel is tripped, each gate it controls drives the idle level of its configured polarity, which is not always logic zero.

Top module: `gate_kill_stage`

## Requirements
- R1: One clock after `main_tripped` becomes 1, every bit of `phase_gate_o` equals the inverse of the matching `out_active_high` bit, and it stays there whatever `phase_pwm_i` does while tripped.
- R2: A PFC fault trip sets only `pfc_tripped` and forces only `pfc_gate_o` to the inverse of `out_active_high[6]`, while `phase_gate_o` keeps following its PWM inputs; a main trip leaves `pfc_gate_o` following `pfc_pwm_i`.
- R3: A fault pin counts as asserted when its level equals its polarity bit (`main_flt_active_high`, `pfc_flt_active_high`): 1 means high asserts and 0 means low asserts.
- R4: A channel trips on the N-th consecutive asserted sample, where N is `filt_len` and a value of 0 is treated as 1. A pulse spanning fewer than N samples never trips, and any deasserted sample restarts the count.
- R5: With the pin asserted from just before clock edge 1, the status flag rises at edge N+2 and the gates are forced at edge N+3. A trip therefore completes within 100 clocks for any N up to 97.
- R6: Bit i of `out_active_high` sets the polarity of gate i. A 1 gives a gate that follows its PWM input, and a 0 gives an inverted gate. Bits 0 to 5 map to `phase_gate_o[5:0]` (UH, UL, VH, VL, WH, WL), and bit 6 maps to `pfc_gate_o`.
- R7: When a gate's channel is not tripped, a PWM input change reaches its gate output at the next clock edge.
- R8: A tripped status stays set until its clear input is high on an edge where the synchronised pin is deasserted. A clear given while the fault is still asserted is ignored.
- R9: During and right after reset, both status flags read 0 and every gate output drives its inactive level.

Assumptions stated as requirements: `filt_len` is held stable while a fault pin is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_pwm_i | input | 6 | Raw phase PWM, active-high, UH UL VH VL WH WL |
| pfc_pwm_i | input | 1 | Raw PFC PWM, active-high |
| main_flt_pin | input | 1 | Main fault pin (asynchronous) |
| pfc_flt_pin | input | 1 | PFC fault pin (asynchronous) |
| main_flt_active_high | input | 1 | Main fault polarity, 1 = high asserts |
| pfc_flt_active_high | input | 1 | PFC fault polarity, 1 = high asserts |
| filt_len | input | 7 | Consecutive samples needed to trip (0 acts as 1) |
| out_active_high | input | 7 | Per-gate polarity, bit 6 = PFC |
| main_clr | input | 1 | Clear request for the main trip latch |
| pfc_clr | input | 1 | Clear request for the PFC trip latch |
| phase_gate_o | output | 6 | Phase gate pins |
| pfc_gate_o | output | 1 | PFC gate pin |
| main_tripped | output | 1 | Latched main fault status |
| pfc_tripped | output | 1 | Latched PFC fault status |

## Verification
A filter counter that fails to restart shows up as a status flag rising after a broken train of short pulses. Such a false trip appears at most N+2 clocks after the last pulse. A wrong trip latch shows up in two ways: the status flag drops while the pin is still asserted, or the gates stay forced after a valid clear. The gates respond one edge after the status changes in either direction. A kill that selects the wrong channel, or that drives a constant zero instead of the idle level, shows up on the very next edge as a gate that mismatches its inverted polarity bit, or as the other channel's gate going dead.

// File: rtl/gks_pkg.sv
// Shared constants for the gate-kill output stage.
package gks_pkg;
    localparam int NUM_PHASE_GATES = 6;
    localparam int NUM_FAULT_CH    = 2;
    localparam int CH_MAIN         = 0;
    localparam int CH_PFC          = 1;
endpackage

// File: rtl/fault_filter.sv
// Fault channel: two-flop synchroniser, polarity select, consecutive-sample
// glitch filter and trip latch.
// Assumes: len is stable while the pin is asserted; a len of 0 acts as 1.
module fault_filter #(
    parameter int FILT_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin,
    input  logic              active_high,
    input  logic [FILT_W-1:0] len,
    input  logic              clr,
    output logic              kill
);
    logic [1:0]        sync_q;
    logic              asserted;
    logic [FILT_W-1:0] run_cnt;
    logic [FILT_W-1:0] len_eff;
    logic              hit;

    // Combinational decode of the sampled level and of the trip condition.
    always_comb begin
        len_eff  = (len == '0) ? FILT_W'(1) : len;
        asserted = (sync_q[1] == active_high);
        hit      = asserted && (run_cnt >= len_eff - FILT_W'(1));
    end

    // Bring the asynchronous pin into the clock domain, reset to the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= {2{~active_high}};
        else        sync_q <= {sync_q[0], pin};
    end

    // Count consecutive asserted samples; restart on any deasserted sample.
    always_ff @(posedge clk) begin
        if (!rst_n)             run_cnt <= '0;
        else if (!asserted)     run_cnt <= '0;
        else if (run_cnt < len_eff) run_cnt <= run_cnt + FILT_W'(1);
    end

    // Trip latch: set on a filter hit, clear only once the fault has gone idle.
    always_ff @(posedge clk) begin
        if (!rst_n)               kill <= 1'b0;
        else if (hit)             kill <= 1'b1;
        else if (clr && !asserted) kill <= 1'b0;
    end

    AST_TRIP_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(kill) |-> $past(asserted)); // R4
    AST_KILL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        kill && !clr |=> kill); // R8
    AST_CLEAR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        kill && asserted |=> kill); // R8
endmodule

// File: rtl/gate_driver.sv
// Output register for a group of gates: applies per-gate polarity and
// forces the idle level of that polarity while kill is high.
// Assumes: pwm inputs are active-high and synchronous to clk.
module gate_driver #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pwm,
    input  logic [W-1:0] active_high,
    input  logic         kill,
    output logic [W-1:0] gate
);
    // Register each gate: idle level in reset or kill, else polarity-mapped PWM.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) gate <= ~active_high;
        else                gate <= pwm ^ ~active_high;
    end

    AST_KILL_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> gate == ~$past(active_high)); // R1
    AST_PWM_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !kill |=> gate == ($past(pwm) ^ ~$past(active_high))); // R7
endmodule

// File: rtl/gate_kill_stage.sv
// Gate-kill output stage: two filtered fault channels (main, PFC) driving the
// phase and PFC gate registers with per-gate polarity.
// Assumes: configuration inputs are quasi-static; fault pins are asynchronous.
module gate_kill_stage
    import gks_pkg::*;
#(
    parameter int FILT_W = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_PHASE_GATES-1:0] phase_pwm_i,
    input  logic                       pfc_pwm_i,
    input  logic                       main_flt_pin,
    input  logic                       pfc_flt_pin,
    input  logic                       main_flt_active_high,
    input  logic                       pfc_flt_active_high,
    input  logic [FILT_W-1:0]          filt_len,
    input  logic [NUM_PHASE_GATES:0]   out_active_high,
    input  logic                       main_clr,
    input  logic                       pfc_clr,
    output logic [NUM_PHASE_GATES-1:0] phase_gate_o,
    output logic                       pfc_gate_o,
    output logic                       main_tripped,
    output logic                       pfc_tripped
);
    logic [NUM_FAULT_CH-1:0] flt_pin;
    logic [NUM_FAULT_CH-1:0] flt_pol;
    logic [NUM_FAULT_CH-1:0] flt_clr;
    logic [NUM_FAULT_CH-1:0] flt_kill;

    // Gather per-channel fault inputs into indexable vectors.
    always_comb begin
        flt_pin[CH_MAIN] = main_flt_pin;
        flt_pin[CH_PFC]  = pfc_flt_pin;
        flt_pol[CH_MAIN] = main_flt_active_high;
        flt_pol[CH_PFC]  = pfc_flt_active_high;
        flt_clr[CH_MAIN] = main_clr;
        flt_clr[CH_PFC]  = pfc_clr;
    end

    for (genvar c = 0; c < NUM_FAULT_CH; c++) begin : g_flt
        fault_filter #(.FILT_W(FILT_W)) u_filt (
            .clk         (clk),
            .rst_n       (rst_n),
            .pin         (flt_pin[c]),
            .active_high (flt_pol[c]),
            .len         (filt_len),
            .clr         (flt_clr[c]),
            .kill        (flt_kill[c])
        );
    end

    gate_driver #(.W(NUM_PHASE_GATES)) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwm         (phase_pwm_i),
        .active_high (out_active_high[NUM_PHASE_GATES-1:0]),
        .kill        (flt_kill[CH_MAIN]),
        .gate        (phase_gate_o)
    );

    gate_driver #(.W(1)) u_pfc (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwm         (pfc_pwm_i),
        .active_high (out_active_high[NUM_PHASE_GATES]),
        .kill        (flt_kill[CH_PFC]),
        .gate        (pfc_gate_o)
    );

    assign main_tripped = flt_kill[CH_MAIN];
    assign pfc_tripped  = flt_kill[CH_PFC];

    AST_PFC_SPARES_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        pfc_tripped && !main_tripped |=>
        phase_gate_o == ($past(phase_pwm_i) ^ ~$past(out_active_high[NUM_PHASE_GATES-1:0]))); // R2
    AST_MAIN_SPARES_PFC: assert property (@(posedge clk) disable iff (!rst_n)
        main_tripped && !pfc_tripped |=>
        pfc_gate_o == ($past(pfc_pwm_i) ^ ~$past(out_active_high[NUM_PHASE_GATES]))); // R2
endmodule

// File: tb/gate_kill_stage_test.sv
module gate_kill_stage_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] phase_pwm_i;
    logic       pfc_pwm_i;
    logic       main_flt_pin, pfc_flt_pin;
    logic       main_flt_active_high, pfc_flt_active_high;
    logic [6:0] filt_len;
    logic [6:0] out_active_high;
    logic       main_clr, pfc_clr;
    logic [5:0] phase_gate_o;
    logic       pfc_gate_o, main_tripped, pfc_tripped;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    gate_kill_stage uut (.*);

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [6:0] exp_gate(input logic [6:0] pwm, input logic [6:0] pol,
                                            input logic kill_m, input logic kill_p);
        logic [6:0] r;
        r = pwm ^ ~pol;
        if (kill_m) r[5:0] = ~pol[5:0];
        if (kill_p) r[6]   = ~pol[6];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic chk_gates(input string req, input logic km, input logic kp);
        chk(req, {25'd0, pfc_gate_o, phase_gate_o},
            {25'd0, exp_gate({pfc_pwm_i, phase_pwm_i}, out_active_high, km, kp)});
    endtask

    task automatic clear_main;
        main_flt_pin = ~main_flt_active_high;
        tick(3);
        main_clr = 1'b1; tick(1); main_clr = 1'b0;
    endtask

    task automatic clear_pfc;
        pfc_flt_pin = ~pfc_flt_active_high;
        tick(3);
        pfc_clr = 1'b1; tick(1); pfc_clr = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        if (!done) $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        phase_pwm_i = 6'b101100; pfc_pwm_i = 1'b1;
        main_flt_pin = 1'b0; pfc_flt_pin = 1'b0;
        main_flt_active_high = 1'b1; pfc_flt_active_high = 1'b1;
        filt_len = 7'd5; out_active_high = 7'b1010101;
        main_clr = 1'b0; pfc_clr = 1'b0;
        tick(3);
        // R9: reset state
        chk("R9 status", {30'd0, main_tripped, pfc_tripped}, 32'd0);
        chk("R9 gates", {25'd0, pfc_gate_o, phase_gate_o}, {25'd0, ~out_active_high});
        rst_n = 1'b1;
        tick(1);

        // R6 R7: random pass-through with random polarity
        for (int i = 0; i < 40; i++) begin
            phase_pwm_i     = 6'($urandom);
            pfc_pwm_i       = 1'($urandom);
            out_active_high = 7'($urandom);
            tick(1);
            chk_gates("R6 R7 pass", 1'b0, 1'b0);
        end

        // R5 R1 R2: main trip timing with N=5
        out_active_high = 7'b0110011;
        main_flt_pin = 1'b1;
        tick(6);
        chk("R5 not yet", {31'd0, main_tripped}, 32'd0);
        tick(1);
        chk("R5 status at N+2", {31'd0, main_tripped}, 32'd1);
        chk_gates("R5 gates still pwm", 1'b0, 1'b0);
        tick(1);
        chk_gates("R1 phase forced, R2 pfc alive", 1'b1, 1'b0);
        phase_pwm_i = ~phase_pwm_i; pfc_pwm_i = ~pfc_pwm_i;
        tick(1);
        chk_gates("R1 hold while tripped", 1'b1, 1'b0);

        // R8: clear ignored while fault asserted
        main_clr = 1'b1; tick(1); main_clr = 1'b0;
        tick(1);
        chk("R8 clear blocked", {31'd0, main_tripped}, 32'd1);
        main_flt_pin = 1'b0;
        tick(6);
        chk("R8 sticky without clear", {31'd0, main_tripped}, 32'd1);
        main_clr = 1'b1; tick(1); main_clr = 1'b0;
        chk("R8 cleared", {31'd0, main_tripped}, 32'd0);
        tick(1);
        chk_gates("R8 gates resume", 1'b0, 1'b0);

        // R4: short pulse and restart on a gap
        main_flt_pin = 1'b1; tick(4); main_flt_pin = 1'b0; tick(10);
        chk("R4 short pulse", {31'd0, main_tripped}, 32'd0);
        main_flt_pin = 1'b1; tick(3); main_flt_pin = 1'b0; tick(1);
        main_flt_pin = 1'b1; tick(3); main_flt_pin = 1'b0; tick(10);
        chk("R4 restart on gap", {31'd0, main_tripped}, 32'd0);

        // R3: low-active main fault
        main_flt_active_high = 1'b0;
        main_flt_pin = 1'b1; tick(12);
        chk("R3 high idle when low-active", {31'd0, main_tripped}, 32'd0);
        main_flt_pin = 1'b0; tick(7);
        chk("R3 low asserts", {31'd0, main_tripped}, 32'd1);
        clear_main();
        chk("R3 cleared", {31'd0, main_tripped}, 32'd0);
        main_flt_active_high = 1'b1; main_flt_pin = 1'b0; tick(3);

        // R2: PFC fault, low-active as well
        pfc_flt_active_high = 1'b0; pfc_flt_pin = 1'b1; tick(3);
        pfc_flt_pin = 1'b0; tick(8);
        chk("R2 pfc status", {30'd0, main_tripped, pfc_tripped}, 32'd1);
        chk_gates("R2 only pfc forced", 1'b0, 1'b1);
        clear_pfc();
        tick(1);
        chk_gates("R2 pfc resumes", 1'b0, 1'b0);
        pfc_flt_active_high = 1'b1; pfc_flt_pin = 1'b0; tick(3);

        // R4: length 0 acts as 1
        filt_len = 7'd0;
        main_flt_pin = 1'b1; tick(1); main_flt_pin = 1'b0; tick(3);
        chk("R4 len0 single sample", {31'd0, main_tripped}, 32'd1);
        clear_main();

        // R4 R5: random length versus random width
        for (int i = 0; i < 30; i++) begin
            int len_r, w_r;
            len_r = 1 + int'($urandom % 8);
            w_r   = 1 + int'($urandom % 12);
            filt_len = 7'(len_r);
            main_flt_pin = 1'b1; tick(w_r);
            main_flt_pin = 1'b0; tick(4);
            chk("R4 random width", {31'd0, main_tripped}, {31'd0, w_r >= len_r});
            clear_main();
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule